// File: doc/BRIEF.md
# Configurable Serial Receive Channel

This block is the receive half of an asynchronous serial channel. It watches one serial data pin, finds the falling edge of a start bit, confirms it half a bit later, and then samples every following bit in the middle of its bit time. The eight data bits it gathers are written to a holding register. A one-cycle completion strobe marks each finished frame.

The frame shape is set at run time, with no reset needed between changes. The settings are the parity rule, one or two stop bits, whether the first data bit goes to the top or the bottom of the byte, and whether the line idles high or low. The bit rate comes from a 7-bit divider setting. One bit lasts twice (divider + 1) cycles of the channel clock.

Three problems are reported as separate sticky flags:
- a bad stop bit;
- a parity mismatch;
- a byte overwritten before it was read.

A frame that raises any of them also pulses an error interrupt. The flags stay set until the clear input is pulsed. A separate read strobe tells the block that the consumer has taken the current byte.

Top module: `cfg_uart_rx`

## Requirements
- R1: With `msb_first_i`=0, the first data bit received after the start bit ends up in bit 0 of `data_o` and the eighth ends up in bit 7.
- R2: With `msb_first_i`=1, the first data bit received ends up in bit 7 of `data_o` and the eighth ends up in bit 0.
- R3: With `invert_i`=1, the pin level is inverted before start detection and sampling, so the line idles low and the start bit is high. The decoded byte is the same as the byte that the equivalent non-inverted frame gives.
- R4: `par_mode_i` selects the parity rule: 0 = no parity bit, 1 = the parity bit must be 0, 2 = even (data plus parity has an even number of ones), 3 = odd. A parity bit that breaks the rule sets `pe_o`.
- R5: `two_stop_i` selects one (0) or two (1) stop bits. A stop bit sampled at the active-low level (after inversion) sets `fe_o`. With two stop bits, a low level on either one counts.
- R6: If a frame completes while the previous byte has not been taken by a pulse on `rd_i`, `ovf_o` is set and `data_o` takes the new byte.
- R7: `fe_o`, `pe_o` and `ovf_o` stay set until `clr_i` is pulsed. A clear in a cycle with no frame completion leaves all three at 0 in the next cycle.
- R8: Every completed frame, including one with errors, gives exactly one single-cycle pulse on `done_o`. `err_irq_o` pulses in the same cycle exactly when that frame raised a framing, parity or overrun error. `data_o` changes only in a cycle where `done_o` is high.
- R9: A low pulse on the line that has ended before the middle of the start bit is rejected, and no frame is produced.
- R10: A bit lasts 2 × (`div_i` + 1) clock cycles. `div_i` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel operation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial data pin |
| div_i | input | 7 | Baud divider setting, 2 or more |
| par_mode_i | input | 2 | Parity rule: 0 none, 1 zero, 2 even, 3 odd |
| two_stop_i | input | 1 | 1 selects two stop bits |
| msb_first_i | input | 1 | 1 places the first data bit in bit 7 |
| invert_i | input | 1 | 1 inverts the pin (idle low) |
| rd_i | input | 1 | Consumer has taken the current byte |
| clr_i | input | 1 | Clears all error flags |
| data_o | output | 8 | Last received byte |
| done_o | output | 1 | Frame-complete pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| fe_o | output | 1 | Sticky framing error flag |
| pe_o | output | 1 | Sticky parity error flag |
| ovf_o | output | 1 | Sticky overrun error flag |

## Verification
The hardest case to reach is a stop bit that is held low. The line is then still active when the frame completes, so a careless receiver would take it for the next start bit. The bench sends frames with either the first or the second stop bit forced low, in every parity, order and polarity combination. It then checks that exactly one completion strobe arrives and that the next clean frame still decodes. Overrun is reached by leaving one byte unread and sending a second frame. Glitch rejection is reached by a low pulse shorter than half a bit, followed by a valid frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ZERO = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5,
        ST_BREAK  = 3'd6
    } rx_state_e;

endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic invert_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb sync_d = pin_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[SYNC_STAGES-1] ^ invert_i;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int DIV_W = 7,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ld_half_i,
    input  logic             ld_full_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_half_i)            cnt_d = {1'b0, div_i};
        else if (ld_full_i)       cnt_d = {div_i, 1'b1};
        else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              tick_i,
    input  logic [1:0]        par_mode_i,
    input  logic              two_stop_i,
    input  logic              msb_first_i,
    output logic              ld_half_o,
    output logic              ld_full_o,
    output logic              frame_done_o,
    output logic [DATA_W-1:0] frame_data_o,
    output logic              frame_fe_o,
    output logic              frame_pe_o
);
    typedef struct packed {
        rx_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              fe;
        logic              pe;
    } fsm_s;

    fsm_s      fsm_d, fsm_q;
    par_mode_e mode;

    assign mode = par_mode_e'(par_mode_i);

    always_comb begin
        fsm_d        = fsm_q;
        ld_half_o    = 1'b0;
        ld_full_o    = 1'b0;
        frame_done_o = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (!line_i) begin
                    ld_half_o = 1'b1;
                    fsm_d.st  = ST_START;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (line_i) begin
                        fsm_d.st = ST_IDLE;
                    end else begin
                        ld_full_o = 1'b1;
                        fsm_d.st  = ST_DATA;
                        fsm_d.idx = '0;
                        fsm_d.par = 1'b0;
                        fsm_d.fe  = 1'b0;
                        fsm_d.pe  = 1'b0;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    ld_full_o = 1'b1;
                    fsm_d.par = fsm_q.par ^ line_i;
                    if (msb_first_i) fsm_d.sh = {fsm_q.sh[DATA_W-2:0], line_i};
                    else             fsm_d.sh = {line_i, fsm_q.sh[DATA_W-1:1]};
                    if (fsm_q.idx == IDX_W'(DATA_W - 1))
                        fsm_d.st = (mode == PAR_NONE) ? ST_STOP1 : ST_PARITY;
                    else
                        fsm_d.idx = fsm_q.idx + 1'b1;
                end
            end
            ST_PARITY: begin
                if (tick_i) begin
                    ld_full_o = 1'b1;
                    unique case (mode)
                        PAR_ZERO: fsm_d.pe = line_i;
                        PAR_EVEN: fsm_d.pe = fsm_q.par ^ line_i;
                        PAR_ODD:  fsm_d.pe = ~(fsm_q.par ^ line_i);
                        default:  fsm_d.pe = 1'b0;
                    endcase
                    fsm_d.st = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (tick_i) begin
                    fsm_d.fe = ~line_i;
                    if (two_stop_i) begin
                        ld_full_o = 1'b1;
                        fsm_d.st  = ST_STOP2;
                    end else begin
                        frame_done_o = 1'b1;
                        fsm_d.st     = line_i ? ST_IDLE : ST_BREAK;
                    end
                end
            end
            ST_STOP2: begin
                if (tick_i) begin
                    fsm_d.fe     = fsm_q.fe | ~line_i;
                    frame_done_o = 1'b1;
                    fsm_d.st     = line_i ? ST_IDLE : ST_BREAK;
                end
            end
            ST_BREAK: begin
                if (line_i) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_IDLE;
            fsm_q.idx <= '0;
            fsm_q.sh  <= '0;
            fsm_q.par <= 1'b0;
            fsm_q.fe  <= 1'b0;
            fsm_q.pe  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign frame_data_o = fsm_d.sh;
    assign frame_fe_o   = fsm_d.fe;
    assign frame_pe_o   = fsm_d.pe;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done_i,
    input  logic [DATA_W-1:0] frame_data_i,
    input  logic              frame_fe_i,
    input  logic              frame_pe_i,
    input  logic              rd_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              err_irq_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              unread;
        logic              done;
        logic              irq;
        logic              fe;
        logic              pe;
        logic              ovf;
    } stat_s;

    stat_s stat_d, stat_q;
    logic  ovf_now;

    always_comb begin
        stat_d      = stat_q;
        stat_d.done = 1'b0;
        stat_d.irq  = 1'b0;
        ovf_now     = stat_q.unread & ~rd_i;
        if (clr_i) begin
            stat_d.fe  = 1'b0;
            stat_d.pe  = 1'b0;
            stat_d.ovf = 1'b0;
        end
        if (rd_i) stat_d.unread = 1'b0;
        if (frame_done_i) begin
            stat_d.data   = frame_data_i;
            stat_d.unread = 1'b1;
            stat_d.done   = 1'b1;
            stat_d.fe     = stat_d.fe  | frame_fe_i;
            stat_d.pe     = stat_d.pe  | frame_pe_i;
            stat_d.ovf    = stat_d.ovf | ovf_now;
            stat_d.irq    = frame_fe_i | frame_pe_i | ovf_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign data_o    = stat_q.data;
    assign done_o    = stat_q.done;
    assign err_irq_o = stat_q.irq;
    assign fe_o      = stat_q.fe;
    assign pe_o      = stat_q.pe;
    assign ovf_o     = stat_q.ovf;
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx #(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       par_mode_i,
    input  logic             two_stop_i,
    input  logic             msb_first_i,
    input  logic             invert_i,
    input  logic             rd_i,
    input  logic             clr_i,
    output logic [7:0]       data_o,
    output logic             done_o,
    output logic             err_irq_o,
    output logic             fe_o,
    output logic             pe_o,
    output logic             ovf_o
);
    localparam int DATA_W = 8;

    logic              line, tick, ld_half, ld_full;
    logic              f_done, f_fe, f_pe;
    logic [DATA_W-1:0] f_data;

    rx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .pin_i(rxd_i), .invert_i(invert_i), .line_o(line)
    );

    rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .div_i(div_i),
        .ld_half_i(ld_half), .ld_full_i(ld_full), .tick_o(tick)
    );

    rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_i(line), .tick_i(tick),
        .par_mode_i(par_mode_i), .two_stop_i(two_stop_i), .msb_first_i(msb_first_i),
        .ld_half_o(ld_half), .ld_full_o(ld_full), .frame_done_o(f_done),
        .frame_data_o(f_data), .frame_fe_o(f_fe), .frame_pe_o(f_pe)
    );

    rx_status_regs #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .frame_done_i(f_done), .frame_data_i(f_data),
        .frame_fe_i(f_fe), .frame_pe_i(f_pe), .rd_i(rd_i), .clr_i(clr_i),
        .data_o(data_o), .done_o(done_o), .err_irq_o(err_irq_o),
        .fe_o(fe_o), .pe_o(pe_o), .ovf_o(ovf_o)
    );
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rxd_i,
    input logic [DIV_W-1:0] div_i,
    input logic [1:0]       par_mode_i,
    input logic             two_stop_i,
    input logic             msb_first_i,
    input logic             invert_i,
    input logic             rd_i,
    input logic             clr_i,
    input logic [7:0]       data_o,
    input logic             done_o,
    input logic             err_irq_o,
    input logic             fe_o,
    input logic             pe_o,
    input logic             ovf_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> done_o); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> $stable(data_o) || done_o); // R8
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fe_o && !clr_i |=> fe_o); // R7
    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pe_o && !clr_i |=> pe_o); // R7
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !done_o |=> !(fe_o || pe_o || ovf_o) || done_o); // R7
    AST_OVF_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> done_o && err_irq_o); // R6
    AST_FE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_o) |-> err_irq_o); // R5
    AST_PE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe_o) |-> err_irq_o); // R4
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        div_i >= DIV_W'(2)); // R10
endmodule

bind cfg_uart_rx rx_checker #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx_checker (.*);

// File: tb/tb_cfg_uart_rx.sv
module tb_cfg_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_i = 1'b1;
    logic [6:0] div_i = 7'd2;
    logic [1:0] par_mode_i = 2'd0;
    logic       two_stop_i = 1'b0;
    logic       msb_first_i = 1'b0;
    logic       invert_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       clr_i = 1'b0;
    logic [7:0] data_o;
    logic       done_o, err_irq_o, fe_o, pe_o, ovf_o;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    logic [7:0] cap_data = 8'h00;
    logic       cap_irq = 1'b0;

    always #10 clk = ~clk;

    cfg_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .div_i(div_i),
        .par_mode_i(par_mode_i), .two_stop_i(two_stop_i), .msb_first_i(msb_first_i),
        .invert_i(invert_i), .rd_i(rd_i), .clr_i(clr_i), .data_o(data_o),
        .done_o(done_o), .err_irq_o(err_irq_o), .fe_o(fe_o), .pe_o(pe_o), .ovf_o(ovf_o)
    );

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            done_cnt <= done_cnt + 1;
            cap_data <= data_o;
            cap_irq  <= err_irq_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_cycles();
        return 2 * (int'(div_i) + 1);
    endfunction

    task automatic drive_bit(input logic b);
        rxd_i = b ^ invert_i;
        repeat (bit_cycles()) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b1);
    endtask

    task automatic send(input logic [7:0] b, input bit bad_par, input int bad_stop);
        logic p;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(msb_first_i ? b[7-i] : b[i]);
        case (par_mode_i)
            2'd1: p = 1'b0;
            2'd2: p = ^b;
            2'd3: p = ~(^b);
            default: p = 1'b0;
        endcase
        if (par_mode_i != 2'd0) drive_bit(p ^ bad_par);
        drive_bit(bad_stop == 1 ? 1'b0 : 1'b1);
        if (two_stop_i) drive_bit(bad_stop == 2 ? 1'b0 : 1'b1);
        idle_bits(2);
    endtask

    task automatic pulse_rd_clr();
        rd_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0; clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] b, input bit bad_par, input int bad_stop);
        int    n0;
        string dtag;
        bit    exp_err;
        n0 = done_cnt;
        send(b, bad_par, bad_stop);
        dtag = invert_i ? "R3" : (msb_first_i ? "R2" : "R1");
        exp_err = bad_par || (bad_stop != 0);
        check(done_cnt == n0 + 1, "R8 one done pulse", done_cnt - n0, 1);
        check(cap_data == b, dtag, cap_data, b);
        check(pe_o == bad_par, "R4 parity flag", pe_o, bad_par);
        check(fe_o == (bad_stop != 0), "R5 framing flag", fe_o, bad_stop != 0);
        check(cap_irq == exp_err, "R8 error irq", cap_irq, exp_err);
        check(ovf_o == 1'b0, "R6 no overrun when read", ovf_o, 0);
        pulse_rd_clr();
        check(!(fe_o || pe_o || ovf_o), "R7 flags cleared", {fe_o, pe_o, ovf_o}, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(data_o == 8'h00 && !done_o && !err_irq_o, "R8 reset outputs", data_o, 0);
        check(!(fe_o || pe_o || ovf_o), "R7 reset flags", {fe_o, pe_o, ovf_o}, 0);

        for (int dv = 2; dv <= 3; dv++)
        for (int md = 0; md < 4; md++)
        for (int ts = 0; ts < 2; ts++)
        for (int mb = 0; mb < 2; mb++)
        for (int iv = 0; iv < 2; iv++) begin
            logic [7:0] b;
            div_i = 7'(dv); par_mode_i = 2'(md); two_stop_i = ts[0];
            msb_first_i = mb[0]; invert_i = iv[0];
            idle_bits(2);
            b = 8'((dv * 37 + md * 11 + ts * 5 + mb * 3 + iv * 7)) ^ 8'h5a;
            run_frame(b, 1'b0, 0);
            run_frame(~b, 1'b0, 0);
            if (md != 0) run_frame(b, 1'b1, 0);
            run_frame(b ^ 8'h81, 1'b0, ts ? 2 : 1);
            if (ts) run_frame(b ^ 8'h18, 1'b0, 1);
        end

        // R10: a slower divider still decodes
        div_i = 7'd20; par_mode_i = 2'd2; two_stop_i = 1'b0; msb_first_i = 1'b0; invert_i = 1'b0;
        idle_bits(2);
        run_frame(8'hC3, 1'b0, 0);
        check(cap_data == 8'hC3, "R10 divider 20", cap_data, 8'hC3);

        // R9: short low pulse rejected, then a clean frame
        begin
            int n0;
            div_i = 7'd3;
            idle_bits(2);
            n0 = done_cnt;
            rxd_i = 1'b0;
            repeat (2) @(negedge clk);
            rxd_i = 1'b1;
            idle_bits(3);
            check(done_cnt == n0, "R9 glitch rejected", done_cnt - n0, 0);
            run_frame(8'h3C, 1'b0, 0);
        end

        // R6: leave one byte unread
        begin
            int n0;
            par_mode_i = 2'd0;
            idle_bits(2);
            n0 = done_cnt;
            send(8'h11, 1'b0, 0);
            check(ovf_o == 1'b0 && cap_irq == 1'b0, "R6 first byte clean", ovf_o, 0);
            send(8'hEE, 1'b0, 0);
            check(done_cnt == n0 + 2, "R8 two frames", done_cnt - n0, 2);
            check(ovf_o == 1'b1, "R6 overrun flag", ovf_o, 1);
            check(data_o == 8'hEE, "R6 newest byte kept", data_o, 8'hEE);
            check(cap_irq == 1'b1, "R6 error irq", cap_irq, 1);
            check(!fe_o && !pe_o, "R6 only overrun", {fe_o, pe_o}, 0);
            idle_bits(2);
            check(ovf_o == 1'b1, "R7 overrun sticky", ovf_o, 1);
            pulse_rd_clr();
            check(ovf_o == 1'b0, "R7 overrun cleared", ovf_o, 0);
        end

        finish_run();
    end
endmodule